// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block holds audio samples for one direction of a serial audio port. On the processor side a small register view gives access to a data register, a control register, a status register and a channel-count register. On the other side the serial engine raises a one-cycle strobe to take a sample (playback build) or to deliver one (capture build). The direction is fixed by a parameter. A second parameter, a 3-bit size code, sets the attached storage to 256 words shifted left by that code.

The usable depth depends on the active channel count. The frame capacity is the word capacity halved once for every doubling needed to reach the channel count. As a result 3, 5, 6 and 7 channels leave part of the storage unused. Occupancy is reported in whole frames. Overrun and underrun are latched as sticky flags. A half-level request can be enabled, and its sense depends on direction: playback asks for more data, capture asks to be drained. A software clear empties the queue in one cycle and is also the only moment at which a newly written channel count takes effect.

Top module: `audio_sample_fifo`

## Requirements
- R1: The storage holds 256<<SIZE_CODE words. The frame capacity is that number shifted right by 0, 1, 2 or 3 for 1, 2, 3–4 or 5–8 channels, and the word capacity is frame capacity times channels. A write once the word count has reached the word capacity is full (256 words: 1ch 256, 3ch 192, 5ch 160).
- R2: Status bits [16:8] report the held frames as floor(words / channels), saturating at 511.
- R3: Only bits [23:0] of a written word are stored. Samples leave in the order they entered. In playback the engine sample appears on `eng_rdata` the cycle after `eng_req`.
- R4: A write to a full FIFO is dropped and sets the sticky overrun flag, status bit 4.
- R5: A take from an empty FIFO returns zero and sets the sticky underrun flag, status bit 0.
- R6: A status write clears each flag whose written bit (4 or 0) is zero, so writing zero clears both. A flag being set in the same cycle wins over the clear.
- R7: Control bit 20 enables `half_irq`. Playback asserts it when held frames are at or below half the frame capacity. Capture asserts it when held frames are at or above half. With the enable at 0 it stays low.
- R8: Writing control bit 0 as 1 empties the FIFO in that cycle. An engine strobe in the same cycle is ignored, the error flags are unchanged, and bit 0 reads back as 0.
- R9: Register 3 bits [2:0] hold channels minus one, pending. Bits [6:4] show the active value. The pending value becomes active only at a clear.
- R10: Register addresses: 0 data, 1 control, 2 status, 3 channels. Read data appears on `cpu_rdata` the cycle after `cpu_rd`. A data read in playback returns 0 and removes nothing. A data write in capture is ignored.
- R11: After reset the FIFO is empty, all flags and enables are 0, the channel count is 1, and both read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 24 | Register write data |
| cpu_rdata | output | 24 | Register read data, one cycle after the read |
| eng_req | input | 1 | Serial engine strobe: take (playback) or give (capture) one sample |
| eng_wdata | input | 24 | Sample delivered by the engine (capture) |
| eng_rdata | output | 24 | Sample taken by the engine (playback), one cycle after the strobe |
| half_irq | output | 1 | Half-level service request |

## Verification
A wrong pointer or word count shows up at the next take as a sample out of order, or on the next status read as a wrong frame level. A bad channel-capacity calculation moves the point at which overrun appears, and the bench probes that point exactly for 1, 3 and 5 channels. Flag and irq errors show on the following cycle, because the reference model is compared with `cpu_rdata`, `eng_rdata` and `half_irq` on every clock.

// File: rtl/afifo_pkg.sv
// Shared register selects, bit positions and geometry helper for the sample FIFO.
package afifo_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CHAN = 2'd3
    } reg_sel_e;

    localparam int BASE_WORDS   = 256;
    localparam int SMP_W        = 24;
    localparam int LVL_W        = 9;
    localparam int CTL_HALF_BIT = 20;
    localparam int CTL_CLR_BIT  = 0;
    localparam int ST_OVR_BIT   = 4;
    localparam int ST_UND_BIT   = 0;
    localparam int ST_LVL_LSB   = 8;
    localparam int CH_ACT_LSB   = 4;

    // Number of halvings for a channel count given as channels-1
    function automatic logic [1:0] chan_shift(input logic [2:0] m1);
        if (m1 == 3'd0)
            return 2'd0;
        else if (m1 == 3'd1)
            return 2'd1;
        else if (m1 <= 3'd3)
            return 2'd2;
        else
            return 2'd3;
    endfunction

endpackage

// File: rtl/afifo_geometry.sv
// Derives frame and word capacity from the active channel count.
// Assumes DEPTH is a power of two of at least 256 words.
module afifo_geometry
    import afifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = 9
) (
    input  logic [2:0]    chan_m1,
    output logic [CW-1:0] frame_cap,
    output logic [CW-1:0] word_cap,
    output logic [CW-1:0] half_cap
);

    logic [CW-1:0] chan_cnt;

    // Capacity arithmetic: round channels up to a power of two for the frame count
    always_comb begin
        chan_cnt  = CW'(chan_m1) + CW'(1);
        frame_cap = CW'(DEPTH) >> chan_shift(chan_m1);
        word_cap  = frame_cap * chan_cnt;
        half_cap  = frame_cap >> 1;
    end

endmodule

// File: rtl/afifo_store.sv
// Circular sample store whose wrap point is the current word capacity.
// Assumes word_cap only changes together with a clear.
module afifo_store #(
    parameter int DEPTH = 256,
    parameter int CW    = 9,
    parameter int AW    = 8,
    parameter int DW    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [CW-1:0] word_cap,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] word_count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;
    logic          pop_ok;

    // Advance a pointer, wrapping at the last usable word
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] lim);
        if (CW'(p) == lim - CW'(1))
            return '0;
        return p + AW'(1);
    endfunction

    // Occupancy decode and gated accesses
    always_comb begin
        full      = (word_count >= word_cap);
        empty     = (word_count == '0);
        push_ok   = push && !full && !clear;
        pop_ok    = pop && !empty && !clear;
        head_data = mem[rptr];
    end

    // Sample storage write port
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wptr] <= push_data;
    end

    // Pointer and count update, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr       <= '0;
            rptr       <= '0;
            word_count <= '0;
        end else begin
            if (push_ok)
                wptr <= bump(wptr, word_cap);
            if (pop_ok)
                rptr <= bump(rptr, word_cap);
            case ({push_ok, pop_ok})
                2'b10:   word_count <= word_count + CW'(1);
                2'b01:   word_count <= word_count - CW'(1);
                default: word_count <= word_count;
            endcase
        end
    end

endmodule

// File: rtl/afifo_regs.sv
// Register view, direction steering, sticky flags and channel settings.
// Assumes one processor access per cycle; PLAY selects the playback build.
module afifo_regs
    import afifo_pkg::*;
#(
    parameter bit PLAY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [1:0]       cpu_addr,
    input  logic [SMP_W-1:0] cpu_wdata,
    input  logic             eng_req,
    input  logic [SMP_W-1:0] eng_wdata,
    input  logic             full,
    input  logic             empty,
    input  logic [SMP_W-1:0] head_data,
    input  logic [LVL_W-1:0] level,
    output logic             push,
    output logic             pop,
    output logic             clear,
    output logic [SMP_W-1:0] push_data,
    output logic [2:0]       chan_active,
    output logic             half_en,
    output logic             over_flag,
    output logic             under_flag,
    output logic [SMP_W-1:0] cpu_rdata,
    output logic [SMP_W-1:0] eng_rdata
);

    reg_sel_e         sel;
    logic             wr_data, rd_data, wr_ctrl, wr_stat, wr_chan;
    logic [2:0]       chan_pend;
    logic             over_nx, under_nx;
    logic [SMP_W-1:0] rd_val;
    logic             unused_bits;

    // Access decode
    always_comb begin
        sel     = reg_sel_e'(cpu_addr);
        wr_data = cpu_wr && (sel == SEL_DATA);
        rd_data = cpu_rd && (sel == SEL_DATA);
        wr_ctrl = cpu_wr && (sel == SEL_CTRL);
        wr_stat = cpu_wr && (sel == SEL_STAT);
        wr_chan = cpu_wr && (sel == SEL_CHAN);
        clear   = wr_ctrl && cpu_wdata[CTL_CLR_BIT];
    end

    // Direction steering picks which side fills and which side drains
    generate
        if (PLAY) begin : g_play
            assign push      = wr_data;
            assign push_data = cpu_wdata;
            assign pop       = eng_req;
        end else begin : g_cap
            assign push      = eng_req;
            assign push_data = eng_wdata;
            assign pop       = rd_data;
        end
    endgenerate

    assign unused_bits = ^{cpu_wdata, eng_wdata};

    // Next value of the sticky flags: status write clears, error sets and wins
    always_comb begin
        over_nx  = over_flag;
        under_nx = under_flag;
        if (wr_stat) begin
            over_nx  = over_flag && cpu_wdata[ST_OVR_BIT];
            under_nx = under_flag && cpu_wdata[ST_UND_BIT];
        end
        if (push && full && !clear)
            over_nx = 1'b1;
        if (pop && empty && !clear)
            under_nx = 1'b1;
    end

    // Flag, enable and channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_flag   <= 1'b0;
            under_flag  <= 1'b0;
            half_en     <= 1'b0;
            chan_pend   <= 3'd0;
            chan_active <= 3'd0;
        end else begin
            over_flag  <= over_nx;
            under_flag <= under_nx;
            if (wr_ctrl)
                half_en <= cpu_wdata[CTL_HALF_BIT];
            if (wr_chan)
                chan_pend <= cpu_wdata[2:0];
            if (clear)
                chan_active <= chan_pend;
        end
    end

    // Read multiplexer over the pre-update state
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_DATA: if (!PLAY && !empty) rd_val = head_data;
            SEL_CTRL: rd_val[CTL_HALF_BIT] = half_en;
            SEL_STAT: begin
                rd_val[ST_LVL_LSB +: LVL_W] = level;
                rd_val[ST_OVR_BIT]          = over_flag;
                rd_val[ST_UND_BIT]          = under_flag;
            end
            SEL_CHAN: begin
                rd_val[2:0]              = chan_pend;
                rd_val[CH_ACT_LSB +: 3]  = chan_active;
            end
            default: rd_val = '0;
        endcase
    end

    // Registered read data for both sides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
            eng_rdata <= '0;
        end else begin
            if (cpu_rd)
                cpu_rdata <= rd_val;
            if (PLAY && eng_req)
                eng_rdata <= empty ? '0 : head_data;
        end
    end

endmodule

// File: rtl/audio_sample_fifo.sv
// Top of the channel-aware sample FIFO: store, geometry and register view.
// Assumes SIZE_CODE is fixed per instance; IS_PLAYBACK picks the direction.
module audio_sample_fifo
    import afifo_pkg::*;
#(
    parameter bit IS_PLAYBACK = 1'b1,
    parameter int SIZE_CODE   = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [1:0]  cpu_addr,
    input  logic [23:0] cpu_wdata,
    output logic [23:0] cpu_rdata,
    input  logic        eng_req,
    input  logic [23:0] eng_wdata,
    output logic [23:0] eng_rdata,
    output logic        half_irq
);

    localparam int DEPTH = BASE_WORDS << SIZE_CODE;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam logic [CW-1:0] LVL_MAX = CW'((1 << LVL_W) - 1);

    logic             clear, push, pop, full, empty;
    logic             half_en, over_flag, under_flag;
    logic [2:0]       chan_active;
    logic [SMP_W-1:0] push_data, head_data;
    logic [CW-1:0]    word_count, word_cap, frame_cap, half_cap;
    logic [CW-1:0]    chan_cnt, frames_held;
    logic [LVL_W-1:0] level;

    afifo_geometry #(.DEPTH(DEPTH), .CW(CW)) u_geom (
        .chan_m1   (chan_active),
        .frame_cap (frame_cap),
        .word_cap  (word_cap),
        .half_cap  (half_cap)
    );

    afifo_store #(.DEPTH(DEPTH), .CW(CW), .AW(AW), .DW(SMP_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .push       (push),
        .push_data  (push_data),
        .pop        (pop),
        .word_cap   (word_cap),
        .head_data  (head_data),
        .word_count (word_count),
        .full       (full),
        .empty      (empty)
    );

    afifo_regs #(.PLAY(IS_PLAYBACK)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr      (cpu_wr),
        .cpu_rd      (cpu_rd),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .eng_req     (eng_req),
        .eng_wdata   (eng_wdata),
        .full        (full),
        .empty       (empty),
        .head_data   (head_data),
        .level       (level),
        .push        (push),
        .pop         (pop),
        .clear       (clear),
        .push_data   (push_data),
        .chan_active (chan_active),
        .half_en     (half_en),
        .over_flag   (over_flag),
        .under_flag  (under_flag),
        .cpu_rdata   (cpu_rdata),
        .eng_rdata   (eng_rdata)
    );

    // Frame level from the word count, saturated to the status field
    always_comb begin
        chan_cnt    = CW'(chan_active) + CW'(1);
        frames_held = word_count / chan_cnt;
        level       = (frames_held > LVL_MAX) ? {LVL_W{1'b1}} : LVL_W'(frames_held);
    end

    // Half-level request with direction-dependent sense
    always_comb begin
        if (IS_PLAYBACK)
            half_irq = half_en && (frames_held <= half_cap);
        else
            half_irq = half_en && (frames_held >= half_cap);
    end

endmodule

// File: rtl/afifo_checker.sv
// Property checker for the sample FIFO, attached to the top with bind.
module afifo_checker #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          push,
    input logic          pop,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] word_count,
    input logic [CW-1:0] word_cap,
    input logic          over_flag,
    input logic          under_flag,
    input logic [2:0]    chan_active,
    input logic          half_en,
    input logic          half_irq
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) word_count <= word_cap) else $error("count above capacity"); // R1
    AST_FULL_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n) (push && full && !clear) |=> over_flag) else $error("overrun not flagged"); // R4
    AST_EMPTY_SETS_UND: assert property (@(posedge clk) disable iff (!rst_n) (pop && empty && !clear) |=> under_flag) else $error("underrun not flagged"); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clear |=> (word_count == '0)) else $error("clear left data"); // R8
    AST_CLEAR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) clear |=> ($stable(over_flag) && $stable(under_flag))) else $error("clear touched flags"); // R8
    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !clear |=> $stable(chan_active)) else $error("channels changed without clear"); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !half_en |-> !half_irq) else $error("irq while disabled"); // R7

endmodule

bind audio_sample_fifo afifo_checker #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .push        (push),
    .pop         (pop),
    .full        (full),
    .empty       (empty),
    .word_count  (word_count),
    .word_cap    (word_cap),
    .over_flag   (over_flag),
    .under_flag  (under_flag),
    .chan_active (chan_active),
    .half_en     (half_en),
    .half_irq    (half_irq)
);

// File: tb/audio_sample_fifo_test.sv
`timescale 1ns/1ps

// Behavioural reference: a queue plus plain variables, updated per clock.
module afifo_ref #(
    parameter bit PLAY      = 1'b1,
    parameter int SIZE_CODE = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        rd,
    input  logic [1:0]  addr,
    input  logic [23:0] wdata,
    input  logic        eng_req,
    input  logic [23:0] eng_wdata,
    output logic [23:0] exp_rdata,
    output logic [23:0] exp_eng,
    output logic        exp_irq
);
    logic [23:0] q [$];
    int pend, act;
    bit hen, ovr, und;

    function automatic int frames_cap(int ch);
        int f = 256 << SIZE_CODE;
        for (int c = 1; c < ch; c = c * 2) f = f / 2;
        return f;
    endfunction

    always @(posedge clk) begin
        int ch, capw, lvl;
        bit clr, psh, pp, full, emp, no, nu;
        logic [23:0] pd;
        if (!rst_n) begin
            q.delete();
            pend = 0; act = 0; hen = 0; ovr = 0; und = 0;
            exp_rdata = '0; exp_eng = '0; exp_irq = 0;
        end else begin
            ch   = act + 1;
            capw = frames_cap(ch) * ch;
            clr  = wr && addr == 2'd1 && wdata[0];
            psh  = PLAY ? (wr && addr == 2'd0) : eng_req;
            pp   = PLAY ? eng_req : (rd && addr == 2'd0);
            pd   = PLAY ? wdata : eng_wdata;
            full = q.size() >= capw;
            emp  = q.size() == 0;
            if (rd) begin
                case (addr)
                    2'd0: exp_rdata = (PLAY || emp) ? 24'd0 : q[0];
                    2'd1: exp_rdata = hen ? 24'h100000 : 24'd0;
                    2'd2: begin
                        lvl = q.size() / ch;
                        if (lvl > 511) lvl = 511;
                        exp_rdata = 24'((lvl << 8) | (int'(ovr) << 4) | int'(und));
                    end
                    default: exp_rdata = 24'((act << 4) | pend);
                endcase
            end
            if (PLAY && eng_req) exp_eng = emp ? 24'd0 : q[0];
            no = ovr; nu = und;
            if (wr && addr == 2'd2) begin
                no = ovr && wdata[4];
                nu = und && wdata[0];
            end
            if (clr) begin
                q.delete();
                act = pend;
            end else begin
                if (psh && full) no = 1;
                if (pp && emp) nu = 1;
                if (pp && !emp) void'(q.pop_front());
                if (psh && !full) q.push_back(pd);
            end
            ovr = no; und = nu;
            if (wr && addr == 2'd1) hen = wdata[20];
            if (wr && addr == 2'd3) pend = int'(wdata[2:0]);
            ch  = act + 1;
            lvl = q.size() / ch;
            exp_irq = hen && (PLAY ? (lvl <= frames_cap(ch) / 2) : (lvl >= frames_cap(ch) / 2));
        end
    end
endmodule

module audio_sample_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, eng_req = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic [23:0] cpu_wdata = '0, eng_wdata = '0;
    logic [23:0] p_rdata, p_eng, c_rdata, c_eng;
    logic        p_irq, c_irq;
    logic [23:0] rp_rdata, rp_eng, rc_rdata, rc_eng;
    logic        rp_irq, rc_irq;
    int checks = 0, failures = 0;
    logic [23:0] pv, cv;

    always #2.5 clk = ~clk;

    audio_sample_fifo #(.IS_PLAYBACK(1'b1), .SIZE_CODE(0)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(p_rdata), .eng_req(eng_req), .eng_wdata(eng_wdata),
        .eng_rdata(p_eng), .half_irq(p_irq));

    audio_sample_fifo #(.IS_PLAYBACK(1'b0), .SIZE_CODE(0)) uut_cap (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(c_rdata), .eng_req(eng_req), .eng_wdata(eng_wdata),
        .eng_rdata(c_eng), .half_irq(c_irq));

    afifo_ref #(.PLAY(1'b1), .SIZE_CODE(0)) ref_play (
        .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .rd(cpu_rd), .addr(cpu_addr), .wdata(cpu_wdata),
        .eng_req(eng_req), .eng_wdata(eng_wdata), .exp_rdata(rp_rdata), .exp_eng(rp_eng), .exp_irq(rp_irq));

    afifo_ref #(.PLAY(1'b0), .SIZE_CODE(0)) ref_cap (
        .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .rd(cpu_rd), .addr(cpu_addr), .wdata(cpu_wdata),
        .eng_req(eng_req), .eng_wdata(eng_wdata), .exp_rdata(rc_rdata), .exp_eng(rc_eng), .exp_irq(rc_irq));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference models
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 play cpu_rdata vs model", 32'(p_rdata), 32'(rp_rdata));
            chk("R3 play eng_rdata vs model", 32'(p_eng), 32'(rp_eng));
            chk("R7 play half_irq vs model", 32'(p_irq), 32'(rp_irq));
            chk("R10 cap cpu_rdata vs model", 32'(c_rdata), 32'(rc_rdata));
            chk("R3 cap eng_rdata vs model", 32'(c_eng), 32'(rc_eng));
            chk("R7 cap half_irq vs model", 32'(c_irq), 32'(rc_irq));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [23:0] p, output logic [23:0] c);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        p = p_rdata; c = c_rdata;
    endtask

    task automatic eng(input logic [23:0] d, output logic [23:0] p);
        @(negedge clk);
        eng_req = 1'b1; eng_wdata = d;
        @(negedge clk);
        eng_req = 1'b0;
        p = p_eng;
    endtask

    task automatic wr_eng(input logic [1:0] a, input logic [23:0] d, input logic [23:0] e);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d; eng_req = 1'b1; eng_wdata = e;
        @(negedge clk);
        cpu_wr = 1'b0; eng_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog got=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 play rdata at reset", 32'(p_rdata), 0);
        chk("R11 play eng_rdata at reset", 32'(p_eng), 0);
        chk("R11 irq at reset", 32'({p_irq, c_irq}), 0);
        rd(2'd2, pv, cv);
        chk("R11 play status at reset", 32'(pv), 0);
        chk("R11 cap status at reset", 32'(cv), 0);
        rd(2'd3, pv, cv);
        chk("R11 channel reg at reset", 32'(pv), 0);

        // Masked writes and ordered takes
        wr(2'd0, 24'h123456);
        wr(2'd0, 24'h000777);
        wr(2'd0, 24'h00ABCD);
        rd(2'd2, pv, cv);
        chk("R2 play level three frames", 32'(pv), 32'h300);
        chk("R10 cap data write ignored", 32'(cv), 0);
        eng(24'h111111, pv); chk("R3 first sample", 32'(pv), 32'h123456);
        eng(24'h222222, pv); chk("R3 second sample", 32'(pv), 32'h000777);
        eng(24'h333333, pv); chk("R3 third sample", 32'(pv), 32'h00ABCD);
        eng(24'h444444, pv); chk("R5 play empty take returns zero", 32'(pv), 0);
        rd(2'd2, pv, cv);
        chk("R5 play underrun flag", 32'(pv), 32'h001);
        chk("R2 cap level four", 32'(cv), 32'h400);

        // Capture drain by data reads
        rd(2'd0, pv, cv);
        chk("R3 cap first read", 32'(cv), 32'h111111);
        chk("R10 play data read returns zero", 32'(pv), 0);
        rd(2'd0, pv, cv); chk("R3 cap second read", 32'(cv), 32'h222222);
        rd(2'd0, pv, cv); chk("R3 cap third read", 32'(cv), 32'h333333);
        rd(2'd0, pv, cv); chk("R3 cap fourth read", 32'(cv), 32'h444444);
        rd(2'd0, pv, cv); chk("R5 cap empty read returns zero", 32'(cv), 0);
        rd(2'd2, pv, cv); chk("R5 cap underrun flag", 32'(cv), 32'h001);

        // Flag clearing
        wr(2'd2, 24'h000010);
        rd(2'd2, pv, cv);
        chk("R6 play flags cleared", 32'(pv), 0);
        chk("R6 cap flags cleared", 32'(cv), 0);
        wr_eng(2'd2, 24'h0, 24'h555555);
        rd(2'd2, pv, cv);
        chk("R6 play set wins over clear", 32'(pv), 32'h001);
        chk("R2 cap one frame", 32'(cv), 32'h100);
        wr(2'd2, 24'h0);
        rd(2'd0, pv, cv);

        // Fill playback to 256 words and beyond
        for (int i = 0; i < 256; i++) wr(2'd0, 24'(i));
        rd(2'd2, pv, cv);
        chk("R1 play full at 256 frames", 32'(pv), 32'h10000);
        wr(2'd0, 24'hFFFFFF);
        rd(2'd2, pv, cv);
        chk("R4 play overrun on full", 32'(pv), 32'h10010);

        // Half-level request
        wr(2'd1, 24'h100000);
        @(negedge clk);
        chk("R7 play irq low when above half", 32'(p_irq), 0);
        chk("R7 cap irq low when empty", 32'(c_irq), 0);
        for (int i = 0; i < 127; i++) eng(24'(i), pv);
        @(negedge clk);
        chk("R7 play irq low at 129", 32'(p_irq), 0);
        chk("R7 cap irq low at 127", 32'(c_irq), 0);
        eng(24'd127, pv);
        chk("R3 play 128th sample", 32'(pv), 32'd127);
        @(negedge clk);
        chk("R7 play irq high at 128", 32'(p_irq), 1);
        chk("R7 cap irq high at 128", 32'(c_irq), 1);

        // Clear with a concurrent engine strobe
        wr_eng(2'd1, 24'h100001, 24'h999999);
        rd(2'd2, pv, cv);
        chk("R8 play cleared, overrun kept", 32'(pv), 32'h010);
        chk("R8 cap cleared, strobe ignored", 32'(cv), 0);
        rd(2'd1, pv, cv);
        chk("R8 clear bit reads zero", 32'(pv), 32'h100000);
        chk("R7 play irq high when empty", 32'(p_irq), 1);

        // Three channels
        wr(2'd2, 24'h0);
        wr(2'd3, 24'd2);
        rd(2'd3, pv, cv);
        chk("R9 pending set, active unchanged", 32'(pv), 32'h02);
        for (int i = 0; i < 4; i++) wr(2'd0, 24'(i));
        rd(2'd2, pv, cv);
        chk("R9 still one channel before clear", 32'(pv), 32'h400);
        wr(2'd1, 24'h000001);
        rd(2'd3, pv, cv);
        chk("R9 active after clear", 32'(pv), 32'h22);
        for (int i = 0; i < 7; i++) wr(2'd0, 24'(i));
        rd(2'd2, pv, cv);
        chk("R2 seven words three channels", 32'(pv), 32'h200);
        for (int i = 0; i < 185; i++) wr(2'd0, 24'(i));
        rd(2'd2, pv, cv);
        chk("R1 three channels hold 192 words", 32'(pv), 32'h4000);
        wr(2'd0, 24'h1);
        rd(2'd2, pv, cv);
        chk("R1 three channels overrun at 193", 32'(pv), 32'h4010);

        // Five channels
        wr(2'd2, 24'h0);
        wr(2'd3, 24'd4);
        wr(2'd1, 24'h000001);
        for (int i = 0; i < 160; i++) wr(2'd0, 24'(i));
        rd(2'd2, pv, cv);
        chk("R1 five channels hold 160 words", 32'(pv), 32'h2000);
        wr(2'd0, 24'h2);
        rd(2'd2, pv, cv);
        chk("R1 five channels overrun at 161", 32'(pv), 32'h2010);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule